// File: doc/BRIEF.md
# Parallel NOR Flash Command Controller

This block models the command side of a byte-wide parallel NOR flash. A host drives chip-enable, write-enable and output-enable strobes with an address and a data byte. The block turns sequences of bus write cycles into program, sector erase, chip erase, erase suspend, erase resume and reset-to-read operations. A small register array, in which erased locations read all ones, stands in for the cell array. The address bus is wider than the array: command unlock addresses are compared on the full bus, and the array location is the low `ARR_W` bits of the address.

Program and erase run on their own, timed by scaled-down cycle counters. While an operation is running, or while an erase is suspended, a read returns a status byte in place of array data, and the ready/busy output shows whether the array can be used. Programming can only clear bits. A program that asks for a 1 where a 0 is stored never verifies and ends in a timeout state that is left with a reset command.

The default array holds 128 bytes split into five sectors: locations 0-15, 16-23, 24-31, 32-63 and 64-127. In general the boundaries fall at one eighth, three sixteenths, one quarter and one half of the array.

Top module: `nor_flash_ctrl`

## Requirements
- R1: After reset every array location reads FFh, `readyBusy` is 1, and `dataOutEn` is 0 unless `ceN` and `oeN` are low and `weN` is high.
- R2: A write cycle captures the address in the clock where `weN` falls with `ceN` low, and it captures the data in the clock where `weN` rises. A later change of the address before `weN` rises has no effect.
- R3: The writes AAh@555h, 55h@2AAh, A0h@555h and then data@address program that location to old AND data. When this verifies, `readyBusy` is low for exactly `PROG_CYC` clocks. A broken sequence, or one that contains F0h, leaves the array unchanged.
- R4: While a program is busy, a read returns bit7 = NOT of the programmed bit 7, bit6 changing on every completed read, bit5 = 0 before timeout, and bits 4..0 = 0, with `readyBusy` 0.
- R5: While a program is busy, every bus write is ignored.
- R6: A program that needs a 1 over a stored 0 stays busy. After `PROG_LIMIT` clocks bit5 reads 1, while bit7 and bit6 keep their busy behaviour and `readyBusy` stays 0. Only F0h returns to read mode, and the location then holds old AND data.
- R7: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh followed by 30h at any address erases the sector that contains that address. The same sequence ending in 10h@555h erases the whole array. Locations outside the target keep their data.
- R8: While an erase is busy, a read returns bit7 = 0 and bit5 = 0, and bit6 and bit2 change on every completed read. The erase first writes 00h to each target location one per clock, then waits `ERASE_CYC` clocks, then writes FFh one per clock, so `readyBusy` is low for 2*size + `ERASE_CYC` clocks.
- R9: While an erase is running, every write other than B0h is ignored.
- R10: B0h during an erase suspends it. `readyBusy` becomes 1 and reads outside the erased range return array data. Reads inside the range return bit7 = 1, bit6 held, and bit2 changing on every completed read.
- R11: While suspended, only 30h (any address) is accepted. It resumes the erase, which then completes. Other writes are ignored.
- R12: Any write that breaks an unlock or command sequence, F0h included, returns the block to read mode without starting an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Bus address; the array uses the low ARR_W bits |
| dataIn | input | DATA_W | Write data |
| dataOut | output | DATA_W | Array data or status byte |
| dataOutEn | output | 1 | High during a read cycle |
| readyBusy | output | 1 | 1 = ready or suspended, 0 = operation running |

## Verification
The assertions assume the bus strobes are synchronous to `clk` and held for at least one clock per level. They also assume `oeN` rises while `ceN` is still low, so that each read is counted exactly once for the toggle bits. The bench drives every strobe on the falling clock edge, holds each level for at least one full clock, and releases `oeN` one clock before `ceN`. Random program operations mix data that verifies with data that must time out. Directed sequences cover broken unlocks, writes during busy and suspended states, and the exact busy length of an erase.

// File: rtl/nor_pkg.sv
package nor_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_U1, ST_U2, ST_PSET, ST_ESET, ST_EU1, ST_EU2,
    ST_PROG, ST_PFAIL, ST_PREP, ST_EPULSE, ST_EFILL, ST_SUSP
  } ctlState_t;

  typedef enum logic [1:0] {SM_ARRAY, SM_PROG, SM_ERASE, SM_SUSP} statMode_t;

  // strobes from the sequencer to the array datapath
  typedef struct packed {
    logic progWrite;
    logic fillZero;
    logic fillOne;
  } arrStrobe_t;

  localparam logic [7:0] CMD_KEY1   = 8'hAA;
  localparam logic [7:0] CMD_KEY2   = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ESETUP = 8'h80;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_RESUME = 8'h30;
  localparam logic [7:0] CMD_RESET  = 8'hF0;

endpackage

// File: rtl/nor_ctrl.sv
module nor_ctrl
  import nor_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int ARR_W      = 7,
  parameter int DATA_W     = 8,
  parameter int PROG_CYC   = 8,
  parameter int PROG_LIMIT = 40,
  parameter int ERASE_CYC  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ceN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              progOk,
  output arrStrobe_t        strb,
  output logic [ARR_W-1:0]  ptr,
  output logic [ARR_W-1:0]  progAddr,
  output logic [DATA_W-1:0] progData,
  output logic [ARR_W-1:0]  secLo,
  output logic [ARR_W-1:0]  secHi,
  output statMode_t         mode,
  output logic              q5,
  output logic              readyBusy
);
  localparam int DEPTH   = 1 << ARR_W;
  localparam int BND1    = DEPTH / 8;
  localparam int BND2    = BND1 + DEPTH / 16;
  localparam int BND3    = DEPTH / 4;
  localparam int BND4    = DEPTH / 2;
  localparam int CNT_MAX = (PROG_LIMIT > ERASE_CYC) ? PROG_LIMIT : ERASE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [ADDR_W-1:0] KEY_ADDR1 = ADDR_W'(11'h555);
  localparam logic [ADDR_W-1:0] KEY_ADDR2 = ADDR_W'(11'h2AA);

  ctlState_t         state, nState, resumeState;
  logic              weQ, weFall, weRise;
  logic [ADDR_W-1:0] cmdAddr;
  logic [CNT_W-1:0]  cnt;
  logic [ARR_W-1:0]  selLo, selHi, cmdIdx;
  logic              atKey1, isKey1, isKey2;

  assign weFall = weQ & ~weN & ~ceN;
  assign weRise = ~weQ & weN & ~ceN;
  assign atKey1 = (cmdAddr == KEY_ADDR1);
  assign isKey1 = atKey1 && (dataIn == DATA_W'(CMD_KEY1));
  assign isKey2 = (cmdAddr == KEY_ADDR2) && (dataIn == DATA_W'(CMD_KEY2));
  assign cmdIdx = cmdAddr[ARR_W-1:0];

  // sector containing the latched address
  always_comb begin
    if (int'(cmdIdx) < BND1) begin
      selLo = '0;               selHi = ARR_W'(BND1 - 1);
    end else if (int'(cmdIdx) < BND2) begin
      selLo = ARR_W'(BND1);     selHi = ARR_W'(BND2 - 1);
    end else if (int'(cmdIdx) < BND3) begin
      selLo = ARR_W'(BND2);     selHi = ARR_W'(BND3 - 1);
    end else if (int'(cmdIdx) < BND4) begin
      selLo = ARR_W'(BND3);     selHi = ARR_W'(BND4 - 1);
    end else begin
      selLo = ARR_W'(BND4);     selHi = ARR_W'(DEPTH - 1);
    end
  end

  always_comb begin
    nState = state;
    strb   = '0;
    case (state)
      ST_READ: if (weRise && isKey1) nState = ST_U1;
      ST_U1:   if (weRise) nState = isKey2 ? ST_U2 : ST_READ;
      ST_U2:   if (weRise) begin
        if (atKey1 && dataIn == DATA_W'(CMD_PROG))        nState = ST_PSET;
        else if (atKey1 && dataIn == DATA_W'(CMD_ESETUP)) nState = ST_ESET;
        else                                              nState = ST_READ;
      end
      ST_PSET: if (weRise) nState = ST_PROG;
      ST_ESET: if (weRise) nState = isKey1 ? ST_EU1 : ST_READ;
      ST_EU1:  if (weRise) nState = isKey2 ? ST_EU2 : ST_READ;
      ST_EU2:  if (weRise) begin
        if (dataIn == DATA_W'(CMD_SECT) || (atKey1 && dataIn == DATA_W'(CMD_CHIP)))
          nState = ST_PREP;
        else
          nState = ST_READ;
      end
      ST_PROG: begin
        if (cnt == CNT_W'(PROG_CYC - 1) && progOk) begin
          strb.progWrite = 1'b1;
          nState = ST_READ;
        end else if (cnt == CNT_W'(PROG_LIMIT - 1)) begin
          strb.progWrite = 1'b1;
          nState = ST_PFAIL;
        end
      end
      ST_PFAIL: if (weRise && dataIn == DATA_W'(CMD_RESET)) nState = ST_READ;
      ST_PREP: begin
        if (weRise && dataIn == DATA_W'(CMD_SUSP)) nState = ST_SUSP;
        else begin
          strb.fillZero = 1'b1;
          if (ptr == secHi) nState = ST_EPULSE;
        end
      end
      ST_EPULSE: begin
        if (weRise && dataIn == DATA_W'(CMD_SUSP)) nState = ST_SUSP;
        else if (cnt == CNT_W'(ERASE_CYC - 1)) nState = ST_EFILL;
      end
      ST_EFILL: begin
        if (weRise && dataIn == DATA_W'(CMD_SUSP)) nState = ST_SUSP;
        else begin
          strb.fillOne = 1'b1;
          if (ptr == secHi) nState = ST_READ;
        end
      end
      ST_SUSP: if (weRise && dataIn == DATA_W'(CMD_RESUME)) nState = resumeState;
      default: nState = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_READ;
      resumeState <= ST_PREP;
      weQ         <= 1'b1;
      cmdAddr     <= '0;
      cnt         <= '0;
      ptr         <= '0;
      progAddr    <= '0;
      progData    <= '0;
      secLo       <= '0;
      secHi       <= '0;
    end else begin
      state <= nState;
      weQ   <= weN;
      if (weFall) cmdAddr <= addr;
      if (state == ST_PSET && weRise) begin
        progAddr <= cmdIdx;
        progData <= dataIn;
      end
      if (state == ST_EU2 && nState == ST_PREP) begin
        if (dataIn == DATA_W'(CMD_SECT)) begin
          secLo <= selLo; secHi <= selHi; ptr <= selLo;
        end else begin
          secLo <= '0;    secHi <= '1;    ptr <= '0;
        end
      end
      if (strb.fillZero) ptr <= (ptr == secHi) ? secLo : ptr + ARR_W'(1);
      if (strb.fillOne)  ptr <= ptr + ARR_W'(1);
      if (nState == ST_SUSP && state != ST_SUSP) resumeState <= state;
      // the counter survives a suspend so a resumed pulse continues
      if (nState != state && state != ST_SUSP && nState != ST_SUSP)
        cnt <= '0;
      else if (state == ST_PROG || state == ST_EPULSE)
        cnt <= cnt + CNT_W'(1);
    end
  end

  always_comb begin
    case (state)
      ST_PROG, ST_PFAIL:             mode = SM_PROG;
      ST_PREP, ST_EPULSE, ST_EFILL:  mode = SM_ERASE;
      ST_SUSP:                       mode = SM_SUSP;
      default:                       mode = SM_ARRAY;
    endcase
  end

  assign q5        = (state == ST_PFAIL);
  assign readyBusy = (mode == SM_ARRAY) || (mode == SM_SUSP);

  // R5: target of a running program cannot be disturbed by bus writes
  a_r5_prog_target_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG) |=> ($stable(progAddr) && $stable(progData)));

  // R10: suspend is reachable only from an erase phase
  a_r10_susp_from_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUSP && $past(state) != ST_SUSP) |->
      ($past(state) == ST_PREP || $past(state) == ST_EPULSE || $past(state) == ST_EFILL));

  // R6: timeout counter stays within its window
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(CNT_MAX));

  // R3: a verified program leaves busy in the same cycle it writes
  a_r3_done_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG && $past(state) == ST_PROG && nState == ST_READ) |-> strb.progWrite);

endmodule

// File: rtl/nor_data.sv
module nor_data
  import nor_pkg::*;
#(
  parameter int ARR_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ARR_W-1:0]  rdAddr,
  input  arrStrobe_t        strb,
  input  logic [ARR_W-1:0]  ptr,
  input  logic [ARR_W-1:0]  progAddr,
  input  logic [DATA_W-1:0] progData,
  input  logic [ARR_W-1:0]  secLo,
  input  logic [ARR_W-1:0]  secHi,
  input  statMode_t         mode,
  input  logic              q5,
  output logic              progOk,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);
  localparam int DEPTH = 1 << ARR_W;
  localparam int BIT_POLL = DATA_W - 1;
  localparam int BIT_TOG  = 6;
  localparam int BIT_TOUT = 5;
  localparam int BIT_ETOG = 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              oeQ, tog6, tog2, readEnd, inSec;
  logic [DATA_W-1:0] arrWord, progOld;

  assign arrWord = mem[rdAddr];
  assign progOld = mem[progAddr];
  assign progOk  = ((progOld & progData) == progData);
  assign inSec   = (rdAddr >= secLo) && (rdAddr <= secHi);
  assign readEnd = ~oeQ & oeN & ~ceN & weN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      if (strb.progWrite) mem[progAddr] <= progOld & progData;
      if (strb.fillZero)  mem[ptr] <= '0;
      if (strb.fillOne)   mem[ptr] <= '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oeQ  <= 1'b1;
      tog6 <= 1'b0;
      tog2 <= 1'b0;
    end else begin
      oeQ <= oeN;
      if (readEnd) begin
        case (mode)
          SM_PROG:  tog6 <= ~tog6;
          SM_ERASE: begin tog6 <= ~tog6; tog2 <= ~tog2; end
          SM_SUSP:  if (inSec) tog2 <= ~tog2;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    dataOut = '0;
    case (mode)
      SM_PROG: begin
        dataOut[BIT_POLL] = ~progData[BIT_POLL];
        dataOut[BIT_TOG]  = tog6;
        dataOut[BIT_TOUT] = q5;
      end
      SM_ERASE: begin
        dataOut[BIT_TOG]  = tog6;
        dataOut[BIT_ETOG] = tog2;
      end
      SM_SUSP: begin
        if (inSec) begin
          dataOut[BIT_POLL] = 1'b1;
          dataOut[BIT_TOG]  = tog6;
          dataOut[BIT_ETOG] = tog2;
        end else begin
          dataOut = arrWord;
        end
      end
      default: dataOut = arrWord;
    endcase
  end

  assign dataOutEn = ~ceN & ~oeN & weN;

  // R7: array strobes from the sequencer never collide
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.progWrite, strb.fillZero, strb.fillOne}));

  // R8: erase walk stays inside the selected range
  a_r8_fill_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.fillZero || strb.fillOne) |-> (ptr >= secLo && ptr <= secHi));

  // R4: each completed read during a program flips the toggle bit
  a_r4_q6_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (readEnd && mode == SM_PROG) |=> (tog6 != $past(tog6)));

  // R10: suspended reads hold the toggle bit
  a_r10_q6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (readEnd && mode == SM_SUSP) |=> $stable(tog6));

endmodule

// File: rtl/nor_flash_ctrl.sv
module nor_flash_ctrl
  import nor_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int ARR_W      = 7,
  parameter int DATA_W     = 8,
  parameter int PROG_CYC   = 8,
  parameter int PROG_LIMIT = 40,
  parameter int ERASE_CYC  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              readyBusy
);
  arrStrobe_t        strb;
  statMode_t         mode;
  logic [ARR_W-1:0]  ptr, progAddr, secLo, secHi;
  logic [DATA_W-1:0] progData;
  logic              q5, progOk;

  nor_ctrl #(
    .ADDR_W(ADDR_W), .ARR_W(ARR_W), .DATA_W(DATA_W),
    .PROG_CYC(PROG_CYC), .PROG_LIMIT(PROG_LIMIT), .ERASE_CYC(ERASE_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ceN(ceN), .weN(weN), .addr(addr),
    .dataIn(dataIn), .progOk(progOk), .strb(strb), .ptr(ptr),
    .progAddr(progAddr), .progData(progData), .secLo(secLo), .secHi(secHi),
    .mode(mode), .q5(q5), .readyBusy(readyBusy)
  );

  nor_data #(.ARR_W(ARR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .ceN(ceN), .oeN(oeN), .weN(weN),
    .rdAddr(addr[ARR_W-1:0]), .strb(strb), .ptr(ptr), .progAddr(progAddr),
    .progData(progData), .secLo(secLo), .secHi(secHi), .mode(mode), .q5(q5),
    .progOk(progOk), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

endmodule

// File: tb/nor_flash_ctrl_bench.sv
module nor_flash_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11, MW = 7, DW = 8;
  localparam int PCYC = 8, PLIM = 40, ECYC = 16;
  localparam int DEPTH = 1 << MW;
  localparam logic [AW-1:0] K1 = 11'h555, K2 = 11'h2AA;

  logic clk = 1'b0, rst_n = 1'b0, ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic dataOutEn, readyBusy;

  int total = 0, bad = 0, busyCnt = 0;
  bit finished = 0;
  logic [7:0] model [DEPTH];

  nor_flash_ctrl u_nor_flash_ctrl (
    .clk(clk), .rst_n(rst_n), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn), .readyBusy(readyBusy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n && !readyBusy) busyCnt++;

  function automatic int secLoOf(int i);
    if (i < DEPTH/8) return 0;
    if (i < DEPTH/8 + DEPTH/16) return DEPTH/8;
    if (i < DEPTH/4) return DEPTH/8 + DEPTH/16;
    if (i < DEPTH/2) return DEPTH/4;
    return DEPTH/2;
  endfunction
  function automatic int secHiOf(int i);
    if (i < DEPTH/8) return DEPTH/8 - 1;
    if (i < DEPTH/8 + DEPTH/16) return DEPTH/8 + DEPTH/16 - 1;
    if (i < DEPTH/4) return DEPTH/4 - 1;
    if (i < DEPTH/2) return DEPTH/2 - 1;
    return DEPTH - 1;
  endfunction
  function automatic bit willFail(logic [7:0] old, logic [7:0] d);
    return (old & d) != d;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic busWrite2(logic [AW-1:0] aFall, logic [AW-1:0] aRise, logic [7:0] d);
    @(negedge clk); ceN = 1'b0; addr = aFall; weN = 1'b0; dataIn = d;
    @(negedge clk); addr = aRise;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); ceN = 1'b1;
    @(negedge clk);
  endtask
  task automatic busWrite(logic [AW-1:0] a, logic [7:0] d);
    busWrite2(a, a, d);
  endtask
  task automatic busRead(logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); ceN = 1'b0; oeN = 1'b0; addr = a;
    @(negedge clk); d = dataOut; oeN = 1'b1;
    @(negedge clk); ceN = 1'b1;
  endtask
  task automatic progStart(logic [AW-1:0] a, logic [7:0] d);
    busWrite(K1, 8'hAA); busWrite(K2, 8'h55); busWrite(K1, 8'hA0); busWrite(a, d);
  endtask
  task automatic eraseStart(logic [AW-1:0] a, logic [7:0] last);
    busWrite(K1, 8'hAA); busWrite(K2, 8'h55); busWrite(K1, 8'h80);
    busWrite(K1, 8'hAA); busWrite(K2, 8'h55); busWrite(a, last);
  endtask
  task automatic waitReady();
    int n = 0;
    @(negedge clk);
    while (!readyBusy && n < 3000) begin @(negedge clk); n++; end
  endtask
  task automatic checkRange(string tag, int lo, int hi);
    logic [7:0] v;
    for (int i = lo; i <= hi; i++) begin
      busRead(AW'(i), v);
      check(tag, v, model[i]);
    end
  endtask

  initial begin
    logic [7:0] s1, s2, v, d;
    int a;
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 readyBusy", readyBusy, 1);
    check("R1 dataOutEn idle", dataOutEn, 0);
    checkRange("R1 erased array", 0, DEPTH - 1);
    @(negedge clk); ceN = 1'b0; oeN = 1'b0; addr = 0;
    @(negedge clk); check("R1 dataOutEn read", dataOutEn, 1);
    oeN = 1'b1; @(negedge clk); ceN = 1'b1;

    // R3 plain program, busy length
    busyCnt = 0;
    progStart(AW'(3), 8'hA5);
    waitReady();
    model[3] = 8'hA5;
    check("R3 program busy clocks", busyCnt, PCYC);
    busRead(AW'(3), v); check("R3 programmed", v, 8'hA5);

    // R2 address taken at WE fall
    busWrite(K1, 8'hAA); busWrite(K2, 8'h55); busWrite(K1, 8'hA0);
    busWrite2(AW'(7), AW'(9), 8'h3C);
    waitReady();
    model[7] = 8'h3C;
    busRead(AW'(7), v); check("R2 fall address used", v, 8'h3C);
    busRead(AW'(9), v); check("R2 rise address unused", v, 8'hFF);

    // R3 broken unlock
    busWrite(K1, 8'hAA); busWrite(11'h2AB, 8'h55); busWrite(K1, 8'hA0); busWrite(AW'(10), 8'h00);
    @(negedge clk); check("R3 broken seq ready", readyBusy, 1);
    busRead(AW'(10), v); check("R3 broken seq no write", v, 8'hFF);
    // R12 F0 aborts a sequence
    busWrite(K1, 8'hAA); busWrite(AW'(0), 8'hF0); busWrite(K2, 8'h55);
    busWrite(K1, 8'hA0); busWrite(AW'(11), 8'h00);
    @(negedge clk); check("R12 abort ready", readyBusy, 1);
    busRead(AW'(11), v); check("R12 abort no write", v, 8'hFF);

    // R4/R5/R6 program that cannot verify
    progStart(AW'(5), 8'h3C); waitReady(); model[5] = 8'h3C;
    progStart(AW'(5), 8'h55);
    busRead(AW'(5), s1); busRead(AW'(5), s2);
    check("R4 q7 complement", s1[7], 1);
    check("R4 q5 before timeout", s1[5], 0);
    check("R4 low bits zero", s1[4:0], 0);
    check("R4 q6 toggles", s1[6] ^ s2[6], 1);
    check("R4 busy", readyBusy, 0);
    busWrite(AW'(0), 8'hF0);
    check("R5 F0 ignored while programming", readyBusy, 0);
    busWrite(K1, 8'hAA); busWrite(K2, 8'h55);
    check("R5 unlock ignored while programming", readyBusy, 0);
    repeat (PLIM) @(negedge clk);
    busRead(AW'(5), s1); busRead(AW'(5), s2);
    check("R6 q5 set", s1[5], 1);
    check("R6 q7 kept", s1[7], 1);
    check("R6 q6 still toggles", s1[6] ^ s2[6], 1);
    check("R6 busy kept", readyBusy, 0);
    busWrite(AW'(0), 8'hF0);
    check("R6 F0 exits", readyBusy, 1);
    model[5] = 8'h3C & 8'h55;
    busRead(AW'(5), v); check("R6 AND result", v, model[5]);

    // R7/R8/R9 sector erase of 16..23
    progStart(AW'(17), 8'h12); waitReady(); model[17] = 8'h12;
    progStart(AW'(24), 8'h34); waitReady(); model[24] = 8'h34;
    busyCnt = 0;
    eraseStart(AW'(20), 8'h30);
    busRead(AW'(20), s1); busRead(AW'(20), s2);
    check("R8 q7 zero", s1[7], 0);
    check("R8 q5 zero", s1[5], 0);
    check("R8 q6 toggles", s1[6] ^ s2[6], 1);
    check("R8 q2 toggles", s1[2] ^ s2[2], 1);
    check("R8 busy", readyBusy, 0);
    busWrite(AW'(24), 8'h00);
    check("R9 write ignored busy", readyBusy, 0);
    waitReady();
    check("R8 erase busy clocks", busyCnt, 2 * 8 + ECYC);
    for (int i = 16; i <= 23; i++) model[i] = 8'hFF;
    checkRange("R7 sector erased", 16, 23);
    checkRange("R9 neighbour kept", 24, 31);

    // R10/R11 suspend and resume on 32..63
    progStart(AW'(40), 8'h11); waitReady(); model[40] = 8'h11;
    eraseStart(AW'(40), 8'h30);
    busWrite(AW'(0), 8'hB0);
    check("R10 ready when suspended", readyBusy, 1);
    busRead(AW'(5), v); check("R10 outside reads data", v, model[5]);
    busRead(AW'(40), s1); busRead(AW'(45), s2);
    check("R10 q7 one", s1[7], 1);
    check("R10 q6 held", s1[6] ^ s2[6], 0);
    check("R10 q2 toggles", s1[2] ^ s2[2], 1);
    busWrite(AW'(50), 8'h00);
    check("R11 other write ignored", readyBusy, 1);
    busWrite(AW'(3), 8'h30);
    check("R11 resumed busy", readyBusy, 0);
    waitReady();
    for (int i = 32; i <= 63; i++) model[i] = 8'hFF;
    checkRange("R11 sector done", 32, 63);
    busRead(AW'(5), v); check("R11 outside kept", v, model[5]);

    // R3/R6 random programs
    for (int k = 0; k < 24; k++) begin
      a = int'($urandom % DEPTH);
      d = 8'($urandom);
      if ($urandom % 2 == 0) d = d | ~model[a];
      progStart(AW'(a), d);
      if (willFail(model[a], d)) begin
        repeat (PLIM + 4) @(negedge clk);
        busRead(AW'(a), s1);
        check("R6 random timeout", s1[5], 1);
        busWrite(AW'(0), 8'hF0);
      end else begin
        waitReady();
      end
      model[a] = model[a] & d;
      busRead(AW'(a), v); check("R3 random program", v, model[a]);
    end
    checkRange("R3 random array", 0, DEPTH - 1);

    // R7 chip erase
    busyCnt = 0;
    eraseStart(K1, 8'h10);
    waitReady();
    check("R8 chip busy clocks", busyCnt, 2 * DEPTH + ECYC);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    checkRange("R7 chip erased", 0, DEPTH - 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule